// File: doc/BRIEF.md
# Zero-Sequence Three-Phase PWM Modulator

This block turns a pair of signed line-to-line voltage commands and a bus-voltage value into six gate levels for a three-leg inverter. It uses an offset-injection method. Three lower and three upper bounds are formed from the two line voltages. The common-mode offset is placed midway between the highest lower bound and the lowest upper bound. This keeps every leg's low-side node voltage between zero and the bus voltage, so the line-to-line peak can reach the full bus voltage.

All voltages, including the bus value, are given in carrier counts. The caller scales the commands so that the full bus voltage equals the carrier peak `PEAK`. A triangular up/down carrier, with a default period of 2666 cycles (about 15 kHz at 40 MHz), is shared by all three legs. A new command is sampled when `valid_i` is high and takes effect at the next carrier zero. The upper and lower gates of each leg are strict complements. Dead time is left to the external gate driver.

Top module: `zspwm_top`

## Requirements
- R1: While `rst_ni` is low, all six gate outputs are low, the carrier is at 0 and every leg duty is 0.
- R2: The carrier counts up by one per clock from 0 to `PEAK`, then down by one per clock back to 0, and repeats. Its period is 2·`PEAK` cycles.
- R3: With line voltages a = `vab_i`, b = `vbc_i` and bus value d = `vdc_i`, the offset is v0 = floor((L + U)/2). Here L = max(−2a−b, a−b, a+2b) and U = min(3d−2a−b, 3d+a−b, 3d+a+2b).
- R4: Each leg duty is floor(s/3), where s is 2a+b+v0 for leg 0, v0+b−a for leg 1 and v0−a−2b for leg 2. Before the division, s is clamped to the range 0 to 3·`PEAK`, so every duty lies in 0..`PEAK`.
- R5: A command is sampled only on a clock edge where `valid_i` is high. Input values presented while `valid_i` is low do not change any gate output.
- R6: A sampled command moves into the active duties only on a clock edge where the carrier is 0. The gates change to the new duty from the following edge onward.
- R7: On each edge, bit i of `gate_hi_o` becomes (carrier < duty i), using the carrier and the duty from before that edge. Bit i of `gate_lo_o` becomes its complement. The two bits of a leg are never high together.
- R8: A duty of 0 keeps the upper gate low for the whole period. A duty of `PEAK` keeps it high for every cycle except the one where the carrier is at `PEAK`, which gives 2·`PEAK`−1 high cycles per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (40 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe for the command words |
| vab_i | input | DATA_W | Signed line voltage a−b, in carrier counts |
| vbc_i | input | DATA_W | Signed line voltage b−c, in carrier counts |
| vdc_i | input | CNT_W | Unsigned bus voltage, in carrier counts |
| gate_hi_o | output | 3 | Upper-switch gate level per leg (bit 0 = leg a) |
| gate_lo_o | output | 3 | Lower-switch gate level per leg |

## Verification
A sampled command changes nothing until the next carrier zero. The gate levels then follow the new duty one edge after that zero, because the comparator output is itself registered. The carrier position at the strobe therefore sets the delay, which can be anywhere from one cycle to a full period. The reference model keeps the same register stages as behavioural integers: pending duty, active duty, count and direction. Its gate prediction is compared on every falling edge, half a cycle after the edge that produced the value. In addition, once each command has had more than a full period to settle, the upper-gate high time over a whole period is counted and checked against 2·duty−1.

// File: rtl/zspwm_pkg.sv
package zspwm_pkg;
  localparam int unsigned LEGS = 3;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/zspwm_offset.sv
module zspwm_offset #(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned IW     = DATA_W + 4
) (
  input  logic signed [DATA_W-1:0] vab_i,
  input  logic signed [DATA_W-1:0] vbc_i,
  input  logic        [CNT_W-1:0]  vdc_i,
  output logic signed [IW-1:0]     v0_o
);
  logic signed [IW-1:0] a, b, d3;
  logic signed [IW-1:0] lo1, lo2, lo3, up1, up2, up3;
  logic signed [IW-1:0] lo_max, up_min, mid;

  assign a  = IW'(vab_i);
  assign b  = IW'(vbc_i);
  assign d3 = $signed({{(IW-CNT_W){1'b0}}, vdc_i}) * 3;

  // lower bounds keep each node >= 0, upper bounds keep it <= Vdc
  assign lo1 = -(a <<< 1) - b;
  assign lo2 = a - b;
  assign lo3 = a + (b <<< 1);
  assign up1 = d3 + lo1;
  assign up2 = d3 + lo2;
  assign up3 = d3 + lo3;

  always_comb begin
    lo_max = lo1;
    if (lo2 > lo_max) lo_max = lo2;
    if (lo3 > lo_max) lo_max = lo3;
    up_min = up1;
    if (up2 < up_min) up_min = up2;
    if (up3 < up_min) up_min = up3;
  end

  assign mid  = lo_max + up_min;
  assign v0_o = mid >>> 1;
endmodule

// File: rtl/zspwm_leg_scale.sv
module zspwm_leg_scale #(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned IW     = DATA_W + 4,
  parameter int unsigned PEAK   = 1333,
  parameter int unsigned LEG    = 0
) (
  input  logic signed [DATA_W-1:0] vab_i,
  input  logic signed [DATA_W-1:0] vbc_i,
  input  logic signed [IW-1:0]     v0_i,
  output logic        [CNT_W-1:0]  duty_o
);
  localparam int unsigned SW    = CNT_W + 2;
  localparam int unsigned SH    = CNT_W + 4;
  localparam int unsigned PW    = SW + SH;
  localparam int unsigned RECIP = ((1 << SH) + 2) / 3;
  localparam logic signed [IW-1:0] S_MAX = IW'(3 * PEAK);

  logic signed [IW-1:0] a, b, s, s_clip;
  logic        [PW-1:0] prod;

  assign a = IW'(vab_i);
  assign b = IW'(vbc_i);

  generate
    if (LEG == 0) begin : g_leg_a
      assign s = (a <<< 1) + b + v0_i;
    end else if (LEG == 1) begin : g_leg_b
      assign s = b - a + v0_i;
    end else begin : g_leg_c
      assign s = v0_i - a - (b <<< 1);
    end
  endgenerate

  always_comb begin
    if (s < 0)          s_clip = '0;
    else if (s > S_MAX) s_clip = S_MAX;
    else                s_clip = s;
  end

  // exact floor(s/3) for 0 <= s <= 3*PEAK via reciprocal multiply
  assign prod   = PW'(s_clip[SW-1:0]) * PW'(RECIP);
  assign duty_o = CNT_W'(prod >> SH);
endmodule

// File: rtl/zspwm_carrier.sv
module zspwm_carrier
  import zspwm_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned PEAK  = 1333
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;
  dir_e             dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (dir_q == DIR_UP) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(PEAK - 1)) dir_q <= DIR_DOWN;
    end else begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) dir_q <= DIR_UP;
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/zspwm_top.sv
module zspwm_top
  import zspwm_pkg::*;
#(
  parameter int unsigned DATA_W = 14,
  parameter int unsigned CNT_W  = 12,
  parameter int unsigned PEAK   = 1333
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] vab_i,
  input  logic signed [DATA_W-1:0] vbc_i,
  input  logic        [CNT_W-1:0]  vdc_i,
  output logic        [2:0]        gate_hi_o,
  output logic        [2:0]        gate_lo_o
);
  localparam int unsigned IW = DATA_W + 4;

  logic signed [IW-1:0]            v0;
  logic [LEGS-1:0][CNT_W-1:0]      duty_new;
  logic [LEGS-1:0][CNT_W-1:0]      pend_q;
  logic [LEGS-1:0][CNT_W-1:0]      act_q;
  logic [CNT_W-1:0]                carrier_cnt;
  logic                            carrier_zero;
  logic [LEGS-1:0]                 hi_q, lo_q;

  zspwm_offset #(.DATA_W(DATA_W), .CNT_W(CNT_W), .IW(IW)) u_offset (
    .vab_i (vab_i),
    .vbc_i (vbc_i),
    .vdc_i (vdc_i),
    .v0_o  (v0)
  );

  zspwm_carrier #(.CNT_W(CNT_W), .PEAK(PEAK)) u_carrier (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (carrier_cnt),
    .zero_o (carrier_zero)
  );

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    zspwm_leg_scale #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .IW(IW), .PEAK(PEAK), .LEG(g)
    ) u_scale (
      .vab_i  (vab_i),
      .vbc_i  (vbc_i),
      .v0_i   (v0),
      .duty_o (duty_new[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[g] <= '0;
        act_q[g]  <= '0;
        hi_q[g]   <= 1'b0;
        lo_q[g]   <= 1'b0;
      end else begin
        if (valid_i)      pend_q[g] <= duty_new[g];
        if (carrier_zero) act_q[g]  <= pend_q[g];  // glitch-free update point
        hi_q[g] <= (carrier_cnt < act_q[g]);
        lo_q[g] <= !(carrier_cnt < act_q[g]);
      end
    end
  end

  assign gate_hi_o = hi_q;
  assign gate_lo_o = lo_q;
endmodule

// File: rtl/zspwm_chk.sv
module zspwm_chk #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned PEAK  = 1333,
  parameter int unsigned LEGS  = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [2:0]                 gate_hi_o,
  input logic [2:0]                 gate_lo_o,
  input logic [CNT_W-1:0]           carrier_cnt,
  input logic [LEGS-1:0][CNT_W-1:0] act_q
);
  logic started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  p_reset_off_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (gate_hi_o == 3'b000 && gate_lo_o == 3'b000));

  p_no_shoot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_hi_o & gate_lo_o) == 3'b000);

  p_compl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> ((gate_hi_o ^ gate_lo_o) == 3'b111));

  p_carrier_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carrier_cnt <= CNT_W'(PEAK));

  p_carrier_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> (carrier_cnt == CNT_W'($past(carrier_cnt) + 1'b1)
                || $past(carrier_cnt) == CNT_W'(carrier_cnt + 1'b1)));

  p_latch_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && !$stable(act_q)) |-> ($past(carrier_cnt) == '0));

  for (genvar g = 0; g < LEGS; g++) begin : g_bound
    p_duty_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_q[g] <= CNT_W'(PEAK));
  end
endmodule

bind zspwm_top zspwm_chk #(.CNT_W(CNT_W), .PEAK(PEAK), .LEGS(3)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .gate_hi_o   (gate_hi_o),
  .gate_lo_o   (gate_lo_o),
  .carrier_cnt (carrier_cnt),
  .act_q       (act_q)
);

// File: tb/zspwm_top_bench.sv
module zspwm_top_bench;
  localparam int CLK_PERIOD = 25;
  localparam int DATA_W = 14;
  localparam int CNT_W  = 12;
  localparam int PEAK   = 1333;
  localparam int WATCHDOG = 150000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic signed [DATA_W-1:0] vab_i = '0;
  logic signed [DATA_W-1:0] vbc_i = '0;
  logic [CNT_W-1:0] vdc_i = '0;
  logic [2:0] gate_hi_o, gate_lo_o;

  int vectors = 0;
  int fails = 0;
  string tag = "R1";
  bit done = 1'b0;

  // reference state
  int m_cnt, m_up;
  int m_pend[3], m_act[3];
  bit m_hi[3], m_lo[3];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  zspwm_top #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PEAK(PEAK)) u_zspwm_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .vab_i(vab_i), .vbc_i(vbc_i), .vdc_i(vdc_i),
    .gate_hi_o(gate_hi_o), .gate_lo_o(gate_lo_o)
  );

  function automatic int half_floor(int x);
    return (x >= 0) ? x / 2 : -((-x + 1) / 2);
  endfunction

  function automatic int ref_duty(int a, int b, int d, int leg);
    int lmax, umin, v0, s;
    lmax = -2*a - b;
    if (a - b > lmax) lmax = a - b;
    if (a + 2*b > lmax) lmax = a + 2*b;
    umin = 3*d - 2*a - b;
    if (3*d + a - b < umin) umin = 3*d + a - b;
    if (3*d + a + 2*b < umin) umin = 3*d + a + 2*b;
    v0 = half_floor(lmax + umin);
    case (leg)
      0: s = 2*a + b + v0;
      1: s = v0 + b - a;
      default: s = v0 - a - 2*b;
    endcase
    if (s < 0) s = 0;
    if (s > 3*PEAK) s = 3*PEAK;
    return s / 3;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_up = 1;
      for (int i = 0; i < 3; i++) begin
        m_pend[i] = 0; m_act[i] = 0; m_hi[i] = 0; m_lo[i] = 0;
      end
    end else begin
      for (int i = 0; i < 3; i++) begin
        m_hi[i] = (m_cnt < m_act[i]);
        m_lo[i] = !m_hi[i];
        if (m_cnt == 0) m_act[i] = m_pend[i];
        if (valid_i) m_pend[i] = ref_duty(int'(vab_i), int'(vbc_i), int'(vdc_i), i);
      end
      if (m_up == 1) begin
        m_cnt++;
        if (m_cnt == PEAK) m_up = 0;
      end else begin
        m_cnt--;
        if (m_cnt == 0) m_up = 1;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk_i) begin
    if (!done) begin
      for (int i = 0; i < 3; i++) begin
        vectors++;
        if (gate_hi_o[i] !== m_hi[i] || gate_lo_o[i] !== m_lo[i]) begin
          fails++;
          $display("FAIL %s leg%0d hi/lo actual %b%b expected %b%b at %0t",
                   tag, i, gate_hi_o[i], gate_lo_o[i], m_hi[i], m_lo[i], $time);
        end
      end
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic apply(int a, int b, int d);
    @(negedge clk_i);
    valid_i = 1'b1; vab_i = DATA_W'(a); vbc_i = DATA_W'(b); vdc_i = CNT_W'(d);
    @(negedge clk_i);
    valid_i = 1'b0;
    vab_i = DATA_W'(-7777); vbc_i = DATA_W'(4321); vdc_i = CNT_W'(17); // ignored (R5)
  endtask

  // count upper-gate high cycles of a leg over one full carrier period
  task automatic count_check(string req, int leg, int exp_duty);
    int hc = 0;
    int expc;
    for (int k = 0; k < 2*PEAK; k++) begin
      @(negedge clk_i);
      if (gate_hi_o[leg] === 1'b1) hc++;
    end
    expc = (exp_duty == 0) ? 0 : 2*exp_duty - 1;
    vectors++;
    if (hc != expc) begin
      fails++;
      $display("FAIL %s leg%0d high cycles actual %0d expected %0d", req, leg, hc, expc);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired, run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tag = "R1";
    #(CLK_PERIOD*3);
    vectors++;
    if (gate_hi_o !== 3'b000 || gate_lo_o !== 3'b000) begin
      fails++;
      $display("FAIL R1 reset gates actual %b/%b expected 000/000", gate_hi_o, gate_lo_o);
    end
    @(negedge clk_i); rst_ni = 1'b1;

    // R8 / R5: no command sampled, duty 0 everywhere
    tag = "R8";
    count_check("R8", 0, 0);
    tag = "R5";
    cycles(100);

    // R3/R4: zero line voltages, offset centres all legs
    tag = "R3";
    apply(0, 0, PEAK);
    cycles(2*PEAK + 5);
    count_check("R3", 0, 666);
    count_check("R2", 2, 666);

    // R4: unbalanced command, mid-period strobe (R6 timing)
    tag = "R6";
    cycles(400);
    apply(1000, -500, PEAK);
    cycles(2*PEAK + 5);
    tag = "R4";
    count_check("R4", 0, 1166);
    count_check("R4", 1, 166);
    count_check("R4", 2, 666);

    // R4: saturated command clamps
    tag = "R4";
    apply(8000, -8000, PEAK);
    cycles(3*PEAK);

    // R8: full-scale leg at PEAK, others at 0
    tag = "R8";
    apply(PEAK, 0, PEAK);
    cycles(2*PEAK + 5);
    count_check("R8", 0, PEAK);
    count_check("R8", 1, 0);

    // R5: two strobes inside one period, last one wins at zero
    tag = "R5";
    cycles(200);
    apply(-600, 300, 1200);
    cycles(50);
    apply(200, 400, 1000);
    cycles(3*PEAK);

    // R7: lower bus value, negative commands
    tag = "R7";
    apply(-900, -200, 1100);
    cycles(3*PEAK);
    count_check("R7", 1, ref_duty(-900, -200, 1100, 1));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule